// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block drives an external memory bus where the low address byte and the data byte share one 8-bit port, and a second port carries the high address byte. The core presents one request at a time: a program fetch, a data read or a data write. The block turns each request into a fixed pattern of strobes, counted in input-clock periods. These strobes are an active-high address-latch strobe, an active-low program-store enable, and active-low read and write strobes. It also sets the direction of the shared port. Bytes that are fetched or read are returned to the core with a one-cycle valid pulse.

Time is divided into bus slots of six clock periods, which is half of a twelve-period machine cycle. A program fetch, or an idle slot, takes one slot. A data read or write takes two slots, and the address-latch pulse of the second slot is suppressed. A pending request is taken only at the boundary where a transaction ends. When no request is pending, the block runs idle slots that keep the address-latch strobe pulsing. Tick numbers below count clock periods from 0 at the start of a transaction.

Top module: `mbus_ext_seq`

## Requirements
- R1: `ale` is high in ticks 0 and 1 of every slot and low otherwise. Each pulse is exactly two periods wide, which gives one pulse every six periods while fetches or idle slots run.
- R2: During a data read or write (twelve ticks), `ale` stays low in ticks 6 and 7, so the pulse of the second slot is dropped.
- R3: `ad_oe` is high and `ad_out` carries the low address byte in ticks 0 to 2, so the address is valid one period before `ale` falls and for one period after it falls.
- R4: For a fetch, `psen_n` is low in ticks 3 to 5 (it falls one period after `ale` falls and stays low for three periods). It is high in every other tick and for reads and writes.
- R5: For a read, `rd_n` is low in ticks 5 to 10 (it falls three periods after `ale` falls and stays low for six periods). It is high otherwise.
- R6: For a write, `wr_n` is low in ticks 5 to 10. `ad_oe` is high and `ad_out` carries the write byte in ticks 4 to 11, one period before `wr_n` falls until one period after it rises.
- R7: `a_hi` is the high address byte of the current transaction. It changes only in tick 0 of a new transaction and holds through idle slots.
- R8: While `rst` (synchronous, active high) is sampled high, `ale`, `psen_n`, `rd_n` and `wr_n` are high, and `ad_oe`, `req_ack` and `rsp_valid` are low.
- R9: `ad_oe` is low in every tick outside the address and write-data windows. In particular it is low whenever `psen_n` or `rd_n` is low.
- R10: `ad_in` is sampled on the clock edge that ends the last low period of `psen_n` (fetch) or of `rd_n` (read). `rsp_valid` is high for the single following cycle, with that byte on `rsp_data`.
- R11: `req_valid` is sampled only on the edge that ends the last tick of a transaction. `req_op` is encoded as 00 for a fetch, 01 for a read, and 10 or 11 for a write. `req_ack` is high in tick 0 of each accepted transaction, and when no request is pending an idle slot runs instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; one period is the bus time unit |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending; held until `req_ack` |
| req_op | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| req_ack | output | 1 | Request taken; high in tick 0 |
| rsp_valid | output | 1 | Returned byte valid for one cycle |
| rsp_data | output | 8 | Fetched or read byte |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared port output: low address or write data |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input from memory |
| a_hi | output | 8 | High address byte |

## Verification
The assertions check relations between the strobes on every cycle. The address-latch pulse is exactly two periods wide. No address-latch pulse appears while a read or write strobe is low. The program-store enable never overlaps a data strobe. The shared port is released whenever memory may drive it and is driven while the write strobe is low. The high address moves only at a rising address-latch strobe. A response appears as the read strobe rises. The exact tick positions, the correct byte on the shared port, the dropped pulse in the second slot, the request handshake and reset in the middle of a transaction can only be shown by the bench's scenarios. These include back-to-back fetches, data accesses in a row, idle gaps and both write encodings, all compared against a tick-by-tick model.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FETCH = 2'd1,
    OP_RD    = 2'd2,
    OP_WR    = 2'd3
  } op_e;

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic rd_n;
    logic wr_n;
    logic oe;
    logic drv_data;
  } bus_ctl_t;

  // request code: 00 fetch, 01 read, 1x write
  function automatic op_e decode_req(input logic [1:0] code);
    case (code)
      2'b00:   return OP_FETCH;
      2'b01:   return OP_RD;
      default: return OP_WR;
    endcase
  endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SLOT_LEN = 6,
  parameter int RD_CAP   = 10,
  parameter int TICK_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [TICK_W-1:0] nxt_tick,
  output op_e               nxt_op,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [DATA_W-1:0] nxt_wdata,
  output logic              take,
  output logic              cap_now
);

  localparam logic [TICK_W-1:0] SLOT_END = TICK_W'(SLOT_LEN - 1);
  localparam logic [TICK_W-1:0] DATA_END = TICK_W'(2 * SLOT_LEN - 1);
  localparam logic [TICK_W-1:0] RD_TICK  = TICK_W'(RD_CAP);

  logic [TICK_W-1:0] tick_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              two_slot;
  logic              last;

  assign two_slot = (op_q == OP_RD) || (op_q == OP_WR);
  assign last     = (tick_q == (two_slot ? DATA_END : SLOT_END));
  assign take     = last && req_valid;

  always_comb begin
    nxt_tick  = last ? '0 : tick_q + TICK_W'(1);
    nxt_op    = op_q;
    nxt_addr  = addr_q;
    nxt_wdata = wdata_q;
    if (last) begin
      nxt_op = req_valid ? decode_req(req_op) : OP_IDLE;
      if (req_valid) begin
        nxt_addr  = req_addr;
        nxt_wdata = req_wdata;
      end
    end
  end

  assign cap_now = ((op_q == OP_FETCH) && (tick_q == SLOT_END)) ||
                   ((op_q == OP_RD)    && (tick_q == RD_TICK));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= SLOT_END;
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      tick_q  <= nxt_tick;
      op_q    <= nxt_op;
      addr_q  <= nxt_addr;
      wdata_q <= nxt_wdata;
    end
  end

endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
#(
  parameter int TICK_W   = 4,
  parameter int ALE_W    = 2,
  parameter int PSEN_DLY = 1,
  parameter int PSEN_W   = 3,
  parameter int STB_DLY  = 3,
  parameter int STB_W    = 6
) (
  input  logic [TICK_W-1:0] tick,
  input  op_e               op,
  output bus_ctl_t          ctl
);

  localparam logic [TICK_W-1:0] ALE_T  = TICK_W'(ALE_W);
  localparam logic [TICK_W-1:0] PS_ON  = TICK_W'(ALE_W + PSEN_DLY);
  localparam logic [TICK_W-1:0] PS_OFF = TICK_W'(ALE_W + PSEN_DLY + PSEN_W);
  localparam logic [TICK_W-1:0] ST_ON  = TICK_W'(ALE_W + STB_DLY);
  localparam logic [TICK_W-1:0] ST_OFF = TICK_W'(ALE_W + STB_DLY + STB_W);
  localparam logic [TICK_W-1:0] WD_ON  = TICK_W'(ALE_W + STB_DLY - 1);

  logic addr_ph, psen_ph, stb_ph, wdat_ph;

  always_comb begin
    addr_ph = (tick <= ALE_T);
    psen_ph = (op == OP_FETCH) && (tick >= PS_ON) && (tick < PS_OFF);
    stb_ph  = (tick >= ST_ON) && (tick < ST_OFF);
    wdat_ph = (op == OP_WR) && (tick >= WD_ON) && (tick <= ST_OFF);

    ctl.ale      = (tick < ALE_T);
    ctl.psen_n   = !psen_ph;
    ctl.rd_n     = !((op == OP_RD) && stb_ph);
    ctl.wr_n     = !((op == OP_WR) && stb_ph);
    ctl.oe       = addr_ph || wdat_ph;
    ctl.drv_data = wdat_ph;
  end

endmodule

// File: rtl/mbus_capture.sv
module mbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_now,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap_now;
      if (cap_now) rsp_data <= ad_in;
    end
  end

endmodule

// File: rtl/mbus_ext_seq.sv
module mbus_ext_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int ALE_W    = 2,
  parameter int PSEN_DLY = 1,
  parameter int PSEN_W   = 3,
  parameter int STB_DLY  = 3,
  parameter int STB_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ack,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi
);

  localparam int SLOT_LEN = ALE_W + PSEN_DLY + PSEN_W;
  localparam int DATA_LEN = 2 * SLOT_LEN;
  localparam int TICK_W   = $clog2(DATA_LEN);
  localparam int RD_CAP   = ALE_W + STB_DLY + STB_W - 1;

  logic [TICK_W-1:0] nxt_tick;
  op_e               nxt_op;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_wdata;
  logic              take;
  logic              cap_now;
  bus_ctl_t          ctl;

  mbus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN),
    .RD_CAP(RD_CAP), .TICK_W(TICK_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .nxt_tick(nxt_tick), .nxt_op(nxt_op),
    .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata),
    .take(take), .cap_now(cap_now)
  );

  mbus_decode #(
    .TICK_W(TICK_W), .ALE_W(ALE_W), .PSEN_DLY(PSEN_DLY),
    .PSEN_W(PSEN_W), .STB_DLY(STB_DLY), .STB_W(STB_W)
  ) u_dec (
    .tick(nxt_tick), .op(nxt_op), .ctl(ctl)
  );

  mbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .cap_now(cap_now), .ad_in(ad_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // outputs are registered from the next-tick decode so they align with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b1;
      psen_n  <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ad_oe   <= 1'b0;
      ad_out  <= '0;
      a_hi    <= '0;
      req_ack <= 1'b0;
    end else begin
      ale     <= ctl.ale;
      psen_n  <= ctl.psen_n;
      rd_n    <= ctl.rd_n;
      wr_n    <= ctl.wr_n;
      ad_oe   <= ctl.oe;
      ad_out  <= ctl.drv_data ? nxt_wdata : nxt_addr[DATA_W-1:0];
      a_hi    <= nxt_addr[ADDR_W-1:DATA_W];
      req_ack <= take;
    end
  end

endmodule

// File: rtl/mbus_ext_seq_chk.sv
module mbus_ext_seq_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            psen_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic [HI_W-1:0] a_hi,
  input logic            rsp_valid
);

  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign armed = (age == 2'd3);

  assert_ale_rise_wide_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(ale) |=> ale);
  assert_ale_two_only_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    (ale && $past(ale)) |=> !ale);
  assert_ale_dropped_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (!rd_n || !wr_n) |-> !ale);
  assert_psen_alone_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    !psen_n |-> (rd_n && wr_n));
  assert_wdata_driven_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    (!wr_n || $rose(wr_n)) |-> ad_oe);
  assert_hi_steady_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(a_hi) |-> $rose(ale));
  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (ale && psen_n && rd_n && wr_n && !ad_oe));
  assert_port_released_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    (!psen_n || !rd_n) |-> !ad_oe);
  assert_read_returns_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(rd_n) |-> rsp_valid);

endmodule

bind mbus_ext_seq mbus_ext_seq_chk #(.HI_W(ADDR_W - DATA_W)) i_chk (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .ad_oe(ad_oe), .a_hi(a_hi), .rsp_valid(rsp_valid)
);

// File: tb/test_mbus_ext_seq.sv
module test_mbus_ext_seq;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    int        t;
    logic      two;
    logic      ale, psen_n, rd_n, wr_n, oe;
    logic [7:0] ad;
    logic [7:0] hi;
    logic      ack;
    logic      drive;
    logic [7:0] din;
    logic      rsp_next;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ack, rsp_valid, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] rsp_data, ad_out, a_hi;
  logic [7:0] ad_in = 8'h00;

  int n_cmp = 0;
  int n_bad = 0;

  exp_t q[$];
  logic [15:0] last_addr = '0;
  logic        seen_rst = 1'b1;
  logic        exp_rsp_v = 1'b0;
  logic [7:0]  exp_rsp_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_ext_seq i_mbus_ext_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // kind: 0 idle, 1 fetch, 2 read, 3 write
  task automatic push_txn(input int kind, input logic [15:0] a, input logic [7:0] wd,
                          input logic acked);
    int len;
    len = (kind >= 2) ? 12 : 6;
    for (int t = 0; t < len; t++) begin
      exp_t e;
      logic wph;
      e.t      = t;
      e.two    = (len == 12);
      e.ale    = (t < 2);
      e.psen_n = !(kind == 1 && t >= 3 && t <= 5);
      e.rd_n   = !(kind == 2 && t >= 5 && t <= 10);
      e.wr_n   = !(kind == 3 && t >= 5 && t <= 10);
      wph      = (kind == 3 && t >= 4 && t <= 11);
      e.oe     = (t <= 2) || wph;
      e.ad     = wph ? wd : a[7:0];
      e.hi     = a[15:8];
      e.ack    = acked && (t == 0);
      e.drive  = !e.psen_n || !e.rd_n;
      e.din    = mem_byte(a);
      e.rsp_next = (kind == 1 && t == 5) || (kind == 2 && t == 10);
      q.push_back(e);
    end
  endtask

  // reference model: starts a transaction when the previous one is used up
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      last_addr = '0;
      seen_rst  = 1'b1;
    end else begin
      seen_rst = 1'b0;
      if (q.size() == 0) begin
        if (req_valid) begin
          last_addr = req_addr;
          push_txn((req_op == 2'b00) ? 1 : (req_op == 2'b01) ? 2 : 3,
                   req_addr, req_wdata, 1'b1);
        end else begin
          push_txn(0, last_addr, 8'h00, 1'b0);
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (seen_rst) begin
      chk("R8 ale", {15'd0, ale}, 16'd1);
      chk("R8 psen_n", {15'd0, psen_n}, 16'd1);
      chk("R8 rd_n", {15'd0, rd_n}, 16'd1);
      chk("R8 wr_n", {15'd0, wr_n}, 16'd1);
      chk("R8 ad_oe", {15'd0, ad_oe}, 16'd0);
      chk("R8 req_ack", {15'd0, req_ack}, 16'd0);
      chk("R8 rsp_valid", {15'd0, rsp_valid}, 16'd0);
      exp_rsp_v = 1'b0;
      ad_in = 8'h00;
    end else if (q.size() == 0) begin
      chk("R11 model queue", 16'd0, 16'd1);
    end else begin
      exp_t e;
      e = q.pop_front();
      chk((e.two && (e.t == 6 || e.t == 7)) ? "R2 ale" : "R1 ale", {15'd0, ale}, {15'd0, e.ale});
      chk("R4 psen_n", {15'd0, psen_n}, {15'd0, e.psen_n});
      chk("R5 rd_n", {15'd0, rd_n}, {15'd0, e.rd_n});
      chk("R6 wr_n", {15'd0, wr_n}, {15'd0, e.wr_n});
      chk(e.t <= 2 ? "R3 ad_oe" : "R9 ad_oe", {15'd0, ad_oe}, {15'd0, e.oe});
      if (e.oe) chk(e.t <= 2 ? "R3 ad_out" : "R6 ad_out", {8'd0, ad_out}, {8'd0, e.ad});
      chk("R7 a_hi", {8'd0, a_hi}, {8'd0, e.hi});
      chk("R11 req_ack", {15'd0, req_ack}, {15'd0, e.ack});
      chk("R10 rsp_valid", {15'd0, rsp_valid}, {15'd0, exp_rsp_v});
      if (exp_rsp_v) chk("R10 rsp_data", {8'd0, rsp_data}, {8'd0, exp_rsp_d});
      exp_rsp_v = e.rsp_next;
      exp_rsp_d = e.din;
      ad_in = e.drive ? e.din : ~e.din;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [15:0] a,
                       input logic [7:0] wd, input int gap);
    repeat (gap) @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_wdata = wd;
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    issue(2'b00, 16'h1234, 8'h00, 0);   // back-to-back fetches
    issue(2'b00, 16'h1235, 8'h00, 0);
    issue(2'b01, 16'hA0F3, 8'h00, 0);   // read right after fetch
    issue(2'b10, 16'h7E01, 8'hC3, 0);   // write right after read
    issue(2'b00, 16'h0000, 8'h00, 14);  // idle slots first
    issue(2'b11, 16'hFFFF, 8'h00, 0);   // second write encoding
    issue(2'b01, 16'h00FF, 8'h00, 3);   // request raised mid-slot
    issue(2'b01, 16'h8001, 8'h00, 0);   // reads in a row
    issue(2'b00, 16'hFF00, 8'h00, 0);
    issue(2'b01, 16'h5555, 8'h00, 0);
    repeat (5) @(negedge clk);          // reset in the middle of a read
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    issue(2'b10, 16'h2468, 8'h5A, 0);
    issue(2'b00, 16'h1357, 8'h00, 2);
    repeat (30) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

endmodule